// File: doc/BRIEF.md
# Output Compare PWM Unit

This block holds a free-running up-counter that advances once per timer step and compares it against a programmable compare value. From that comparison it produces a pulse-width-modulated output, a sticky compare flag, a sticky overflow flag and an interrupt request. Software sets the period through a top value and the duty through the compare value.

Both values go first into software-facing registers and are copied into shadow copies only when the counter wraps. The counter and the output logic use only the shadow copies. A new period or duty therefore starts cleanly at the next period boundary, and the waveform never glitches in mid-period.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level or a single-cycle strobe sampled on the rising clock edge. A timer step happens on an edge where `tick` and `run` are both high.

Top module: `cpw_top`

## Requirements
- R1: The counter advances only on an edge where `tick` and `run` are both 1. On any other edge the counter, `pwm_out` and both flags keep their values.
- R2: The counter runs from 0 up to the shadow top value. On the step taken at the shadow top value it returns to 0 and sets `ovf_flag`, so one period lasts top+1 steps.
- R3: A write to the compare value (`cmp_wr`) or to the top value (`top_wr`), carried on `wr_data`, is copied into the shadow copy only at the wrap step. A write made in mid-period first takes effect in the following period.
- R4: `pwm_out` is high for exactly `cmp` steps of each period: it goes high at the wrap and low on the step that brings the counter to the shadow compare value. A compare value of 0 keeps the output low. A compare value above top keeps it high for the whole period.
- R5: `cmp_flag` is set on the step taken while the counter equals the shadow compare value. It is therefore visible one timer cycle after the counter reaches the match value, not in the match cycle itself.
- R6: `irq` is 1 exactly when `cmp_flag` is 1 and `cmp_irq_en` is 1.
- R7: Writing 1 to `flag_clr` bit 0 clears `cmp_flag`, and writing 1 to bit 1 clears `ovf_flag`. A 0 in a bit leaves that flag unchanged.
- R8: If a clear and a set of the same flag happen on the same edge, the flag ends up set.
- R9: After reset the counter is 0, the shadow and software top values are 15, the compare values are 0, `pwm_out` is low, and both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| run | input | 1 | Count enable |
| cmp_wr | input | 1 | Write strobe for the compare value |
| top_wr | input | 1 | Write strobe for the top value |
| wr_data | input | CNT_W | Write data for either value |
| cmp_irq_en | input | 1 | Compare interrupt enable |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 compare flag, bit 1 overflow flag |
| pwm_out | output | 1 | PWM waveform |
| cmp_flag | output | 1 | Sticky compare match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Compare interrupt request |

## Verification
Every result is a register loaded on the step edge, so each result is due at that step edge. `pwm_out` and `ovf_flag` change on the wrap step. `pwm_out` falls on the step that enters the compare value, and `cmp_flag` rises on the step after that, when the counter leaves the compare value. The bench drives inputs just after the falling edge and samples outputs at the next falling edge, so each sample shows exactly the step edge just taken. Period length and duty are measured by counting samples from one observed wrap to the next. Idle cycles are inserted between steps to show that nothing moves without a step.

// File: rtl/cpw_pkg.sv
package cpw_pkg;
  // Bit positions in the write-1-to-clear flag strobe
  localparam int FLG_CMP = 0;
  localparam int FLG_OVF = 1;
  localparam int NFLAG   = 2;
endpackage

// File: rtl/cpw_period.sv
module cpw_period #(
  parameter int CNT_W   = 16,
  parameter int TOP_RST = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top_sh,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP_INIT = CNT_W'(TOP_RST);

  logic [CNT_W-1:0] top_q;

  assign wrap = step && (cnt == top_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q  <= TOP_INIT;
      top_sh <= TOP_INIT;
      cnt    <= '0;
    end else begin
      if (top_wr) top_q <= wr_data;
      if (wrap) begin
        cnt    <= '0;
        top_sh <= top_q;     // new period length starts with the new period
      end else if (step) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpw_compare.sv
module cpw_compare #(
  parameter int CNT_W   = 16,
  parameter int CMP_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cmp_sh,
  output logic             hit,
  output logic             pwm
);
  localparam logic [CNT_W-1:0] CMP_INIT = CNT_W'(CMP_RST);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cmp_q;
  logic [EXT_W-1:0] cnt_nxt;
  logic             fall;

  // Widened so the increment cannot alias at the all-ones count
  assign cnt_nxt = {1'b0, cnt} + 1'b1;
  assign hit     = step && (cnt == cmp_sh);
  assign fall    = step && !wrap && (cnt_nxt == {1'b0, cmp_sh});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= CMP_INIT;
      cmp_sh <= CMP_INIT;
      pwm    <= (CMP_RST != 0);
    end else begin
      if (cmp_wr) cmp_q <= wr_data;
      if (wrap) begin
        cmp_sh <= cmp_q;
        pwm    <= (cmp_q != '0);   // zero duty stays low for the whole period
      end else if (fall) begin
        pwm <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpw_flags.sv
module cpw_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[g] <= 1'b0;
      else if (set[g]) flag[g] <= 1'b1;   // hardware set outranks software clear
      else if (clr[g]) flag[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/cpw_top.sv
module cpw_top
  import cpw_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TOP_RST = 15,
  parameter int CMP_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             cmp_wr,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cmp_irq_en,
  input  logic [1:0]       flag_clr,
  output logic             pwm_out,
  output logic             cmp_flag,
  output logic             ovf_flag,
  output logic             irq
);
  logic             step;
  logic             wrap;
  logic             hit;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_sh;
  logic [CNT_W-1:0] cmp_sh;
  logic [NFLAG-1:0] fl_set;
  logic [NFLAG-1:0] fl_q;

  assign step = tick && run;

  cpw_period #(.CNT_W(CNT_W), .TOP_RST(TOP_RST)) period_i (
    .clk(clk), .rst_n(rst_n), .step(step), .top_wr(top_wr),
    .wr_data(wr_data), .cnt(cnt), .top_sh(top_sh), .wrap(wrap)
  );

  cpw_compare #(.CNT_W(CNT_W), .CMP_RST(CMP_RST)) compare_i (
    .clk(clk), .rst_n(rst_n), .step(step), .wrap(wrap), .cnt(cnt),
    .cmp_wr(cmp_wr), .wr_data(wr_data), .cmp_sh(cmp_sh), .hit(hit),
    .pwm(pwm_out)
  );

  always_comb begin
    fl_set          = '0;
    fl_set[FLG_CMP] = hit;
    fl_set[FLG_OVF] = wrap;
  end

  cpw_flags #(.N(NFLAG)) flags_i (
    .clk(clk), .rst_n(rst_n), .set(fl_set), .clr(flag_clr), .flag(fl_q)
  );

  assign cmp_flag = fl_q[FLG_CMP];
  assign ovf_flag = fl_q[FLG_OVF];
  assign irq      = cmp_flag && cmp_irq_en;
endmodule

// File: rtl/cpw_checker.sv
module cpw_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic [1:0]       flag_clr,
  input logic             pwm_out,
  input logic             cmp_flag,
  input logic             ovf_flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top_sh,
  input logic [CNT_W-1:0] cmp_sh
);
  logic stp, wrp, mat;
  assign stp = tick && run;
  assign wrp = stp && (cnt == top_sh);
  assign mat = stp && (cnt == cmp_sh);

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stp |=> ($stable(cnt) && $stable(pwm_out)));

  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrp |=> (cnt == '0) && ovf_flag);

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top_sh);

  a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrp |=> ($stable(cmp_sh) && $stable(top_sh)));

  a_r4_start_level: assert property (@(posedge clk) disable iff (!rst_n)
    wrp |=> (pwm_out == (cmp_sh != '0)));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    mat |=> cmp_flag);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !mat) |=> !cmp_flag);

  a_r8_ovf_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[1] && wrp) |=> ovf_flag);
endmodule

bind cpw_top cpw_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .flag_clr(flag_clr),
  .pwm_out(pwm_out), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
  .cnt(cnt), .top_sh(top_sh), .cmp_sh(cmp_sh)
);

// File: tb/cpw_top_tb.sv
module cpw_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, run = 1'b0, cmp_wr = 1'b0, top_wr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        cmp_irq_en = 1'b0;
  logic [1:0]  flag_clr = 2'b00;
  logic        pwm_out, cmp_flag, ovf_flag, irq;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;   // 50 MHz

  cpw_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .cmp_wr(cmp_wr),
    .top_wr(top_wr), .wr_data(wr_data), .cmp_irq_en(cmp_irq_en),
    .flag_clr(flag_clr), .pwm_out(pwm_out), .cmp_flag(cmp_flag),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Apply inputs for one rising edge; return at the following falling edge
  task automatic cyc(input logic tk, input logic rn, input logic [1:0] clr,
                     input logic cw, input logic tw, input logic [15:0] d);
    tick = tk; run = rn; flag_clr = clr; cmp_wr = cw; top_wr = tw; wr_data = d;
    @(negedge clk);
  endtask

  task automatic stepc(input logic [1:0] clr);
    cyc(1'b1, 1'b1, clr, 1'b0, 1'b0, 16'd0);
  endtask

  // Leaves the bench just after a wrap edge (counter at 0)
  task automatic sync_wrap();
    int n = 0;
    stepc(2'b10);
    while (!ovf_flag && n < 200) begin stepc(2'b00); n++; end
    chk(ovf_flag, "R2 wrap seen", ovf_flag, 1);
  endtask

  // Walk one period of p steps from a wrap; count high samples
  task automatic measure(input int p, input int exp_hi, input logic cw,
                         input logic tw, input logic [15:0] d,
                         input bit gaps, input bit endclr, input string tag);
    int hi = 0;
    for (int i = 0; i < p; i++) begin
      hi += int'(pwm_out);
      if (i == p - 1) chk(!ovf_flag, {"R2 no early wrap ", tag}, ovf_flag, 0);
      if (gaps) begin
        logic pw = pwm_out, of = ovf_flag, cf = cmp_flag;
        cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 16'd0);
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 16'd0);
        chk(pwm_out == pw && ovf_flag == of && cmp_flag == cf,
            "R1 idle keeps state", {pwm_out, ovf_flag, cmp_flag}, {pw, of, cf});
      end
      cyc(1'b1, 1'b1, (i == 0 || (endclr && i == p - 1)) ? 2'b10 : 2'b00,
          (i == 1) ? cw : 1'b0, (i == 1) ? tw : 1'b0, d);
    end
    chk(ovf_flag, {"R2 R8 wrap at period end ", tag}, ovf_flag, 1);
    chk(hi == exp_hi, {"R4 high count ", tag}, hi, exp_hi);
  endtask

  task automatic t_reset();
    chk(!pwm_out && !cmp_flag && !ovf_flag && !irq, "R9 reset outputs",
        {pwm_out, cmp_flag, ovf_flag, irq}, 0);
    sync_wrap();
    measure(16, 0, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, "R9 reset period 16 duty 0");
  endtask

  task automatic t_shadow();
    measure(16, 0, 1'b1, 1'b0, 16'd4, 1'b0, 1'b0, "R3 old cmp kept");
    measure(16, 4, 1'b0, 1'b1, 16'd9, 1'b0, 1'b0, "R3 old top kept");
    measure(10, 4, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, "R3 new top 9 cmp 4");
  endtask

  task automatic t_flag();
    cmp_irq_en = 1'b1;
    stepc(2'b01);                         // e1: clear, counter 0 -> 1
    for (int i = 2; i <= 4; i++) stepc(2'b00);
    chk(!pwm_out, "R4 fall on entering cmp", pwm_out, 0);
    chk(!cmp_flag, "R5 no flag in match cycle", cmp_flag, 0);
    chk(!irq, "R6 irq low without flag", irq, 0);
    stepc(2'b00);                         // e5: counter leaves 4
    chk(cmp_flag, "R5 flag one cycle after match", cmp_flag, 1);
    chk(irq, "R6 irq with flag and enable", irq, 1);
    stepc(2'b01);
    chk(!cmp_flag, "R7 clear bit 0", cmp_flag, 0);
    sync_wrap();
    for (int i = 1; i <= 4; i++) stepc(2'b00);
    stepc(2'b01);                         // clear on the setting edge
    chk(cmp_flag, "R8 set beats clear", cmp_flag, 1);
    cmp_irq_en = 1'b0;
    stepc(2'b10);
    chk(cmp_flag, "R7 zero bit leaves cmp flag", cmp_flag, 1);
    chk(!ovf_flag, "R7 bit 1 clears ovf", ovf_flag, 0);
    #1 chk(!irq, "R6 irq masked", irq, 0);
    sync_wrap();
  endtask

  task automatic t_duty_edges();
    measure(10, 4, 1'b1, 1'b0, 16'd12, 1'b0, 1'b1, "R8 ovf clear at wrap");
    measure(10, 10, 1'b1, 1'b0, 16'd10, 1'b0, 1'b0, "R4 cmp above top");
    measure(10, 10, 1'b1, 1'b0, 16'd3, 1'b0, 1'b0, "R4 cmp top plus one");
    measure(10, 3, 1'b0, 1'b1, 16'd5, 1'b1, 1'b0, "R1 gapped steps");
    measure(6, 3, 1'b1, 1'b0, 16'd0, 1'b0, 1'b0, "R3 short top 5");
    measure(6, 0, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, "R4 cmp zero low");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_flag();
    t_duty_edges();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule